// File: doc/BRIEF.md
# Debug Hart Control Register

This block is one memory-mapped 32-bit control and status word inside a processor debug module. A debugger reaches it over a plain debug-bus port that carries an address, write data, and write and read strobes. The fields let the debugger choose a target hart, ask that hart to halt or to resume, drive a system reset level, and take the debug module in or out of its own local reset. The word also reports whether authentication has passed.

A halt or resume request goes to the hart named in the same write, not to the one selected earlier. Each request leaves the block as a one-cycle pulse on a per-hart output. A halt pulse is issued only if that hart is not already halted. A resume pulse is issued only if that hart is halted. The module-active field is the only local reset of the debug module. While it is clear, every other field is held at zero and cannot be written. The only thing that clears the module-active field and the system reset field, apart from writes, is power-on reset.

Top module: `dbg_hartctl`

## Requirements
- R1: After power-on reset, `dm_rst_n` and `sys_reset` are 0, and no request pulse is asserted. A read of the word returns only the authentication bit (bit 7).
- R2: A write to any address other than `CTRL_ADDR` changes nothing. A read of any other address returns 0. `rdata` is registered: it carries the read result the cycle after `rd_en` and is 0 in any cycle that follows no read.
- R3: Bit 9 is module-active, and `dm_rst_n` follows it one cycle after the write. Writing it as 0 also clears the system reset field and the hart select field.
- R4: While module-active is 0, writes to every other field are ignored, including the write that sets module-active to 1.
- R5: Bit 8 sets the `sys_reset` level. Writing 1 asserts it and writing 0 releases it, and it holds between writes.
- R6: Bits 25:16 hold a 10-bit hart select that reads back as written.
- R7: Writing bit 31 as 1 gives a one-cycle pulse on `halt_pulse[sel]` in the cycle after the write, where `sel` is bits 25:16 of that same write. The pulse is given only if `hart_halted[sel]` is 0.
- R8: Writing bit 30 as 1 gives a one-cycle pulse on `resume_pulse[sel]` in the cycle after the write. The pulse is given only if `hart_halted[sel]` is 1.
- R9: When bits 31 and 30 are both 1, the write is handled as a halt request alone, and no resume pulse is issued.
- R10: Bits 31 and 30 always read as 0.
- R11: With `HAS_AUTH` = 0, bit 7 reads as 1 whatever `auth_ok` is. With `HAS_AUTH` = 1, bit 7 reads as `auth_ok`.
- R12: A request whose hart select is `NUM_HARTS` or more produces no pulse.
- R13: No request pulse is issued unless module-active was already 1 before the write and the write keeps it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| hart_halted | input | NUM_HARTS | Halted status of each hart |
| auth_ok | input | 1 | Authentication passed (used when `HAS_AUTH` = 1) |
| halt_pulse | output | NUM_HARTS | One-cycle halt request per hart |
| resume_pulse | output | NUM_HARTS | One-cycle resume request per hart |
| sys_reset | output | 1 | System reset level |
| dm_rst_n | output | 1 | Local debug module reset, active low |

## Verification
The bench targets these corner cases:

- **Activating write.** It carries other fields along with it. A design that accepted them would raise `sys_reset` or pulse a hart the moment the module comes alive.
- **Same-write hart select.** A halt is aimed at a newly selected hart. A design that used the stored select would pulse the wrong bit.
- **Requests against hart state.** Halts go to already halted harts and resumes to running ones, and both request bits are set in one write. A design that ignored `hart_halted`, or issued both pulses, would show extra pulses.
- **Deactivation and range.** Clearing module-active must drop `sys_reset` and the select. A hart select beyond `NUM_HARTS` must produce no stray pulse.

// File: rtl/dbg_hartctl_pkg.sv
package dbg_hartctl_pkg;
    localparam int unsigned REG_W      = 32;
    localparam int unsigned HALT_BIT   = 31;
    localparam int unsigned RESUME_BIT = 30;
    localparam int unsigned SEL_LO     = 16;
    localparam int unsigned SEL_W      = 10;
    localparam int unsigned ACTIVE_BIT = 9;
    localparam int unsigned SYSRST_BIT = 8;
    localparam int unsigned AUTH_BIT   = 7;

    typedef logic [SEL_W-1:0] sel_t;

    // stored control state
    typedef struct packed {
        logic active;
        logic sysrst;
        sel_t sel;
    } ctl_t;

    // request decoded from one accepted write
    typedef struct packed {
        logic halt;
        logic resume;
        sel_t sel;
    } req_t;
endpackage

// File: rtl/dbg_hartctl_regs.sv
module dbg_hartctl_regs
    import dbg_hartctl_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             wr_hit,
    input  logic [REG_W-1:0] wdata,
    output ctl_t             ctl_q,
    output req_t             req
);
    ctl_t ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        req   = '0;
        if (wr_hit) begin
            ctl_d.active = wdata[ACTIVE_BIT];
            if (ctl_q.active && wdata[ACTIVE_BIT]) begin
                ctl_d.sysrst = wdata[SYSRST_BIT];
                ctl_d.sel    = wdata[SEL_LO +: SEL_W];
                req.halt     = wdata[HALT_BIT];
                req.resume   = wdata[RESUME_BIT] & ~wdata[HALT_BIT];
                req.sel      = wdata[SEL_LO +: SEL_W];
            end else begin
                ctl_d.sysrst = 1'b0;
                ctl_d.sel    = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // R4
    inactive_fields_chk: assert property (@(posedge clk) disable iff (!por_n)
        !ctl_q.active |-> (!ctl_q.sysrst && ctl_q.sel == '0));

    // R5
    sysrst_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        !$past(wr_hit) |-> $stable(ctl_q.sysrst));

    // R13
    req_needs_active_chk: assert property (@(posedge clk) disable iff (!por_n)
        (req.halt || req.resume) |-> ctl_q.active);
endmodule

// File: rtl/dbg_hartctl_req.sv
module dbg_hartctl_req
    import dbg_hartctl_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 8
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  req_t                 req,
    input  logic [NUM_HARTS-1:0] hart_halted,
    output logic [NUM_HARTS-1:0] halt_pulse,
    output logic [NUM_HARTS-1:0] resume_pulse
);
    logic [NUM_HARTS-1:0] halt_d, halt_q, resume_d, resume_q;

    for (genvar i = 0; i < NUM_HARTS; i++) begin : g_hart
        always_comb begin
            halt_d[i]   = req.halt   && (req.sel == SEL_W'(i)) && !hart_halted[i];
            resume_d[i] = req.resume && (req.sel == SEL_W'(i)) &&  hart_halted[i];
        end

        // R7
        halt_running_chk: assert property (@(posedge clk) disable iff (!por_n)
            halt_q[i] |-> !$past(hart_halted[i]));

        // R8
        resume_halted_chk: assert property (@(posedge clk) disable iff (!por_n)
            resume_q[i] |-> $past(hart_halted[i]));
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            halt_q   <= '0;
            resume_q <= '0;
        end else begin
            halt_q   <= halt_d;
            resume_q <= resume_d;
        end
    end

    assign halt_pulse   = halt_q;
    assign resume_pulse = resume_q;

    // R9
    no_dual_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
        !((|halt_q) && (|resume_q)));

    // R12
    single_target_chk: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({halt_q, resume_q}));
endmodule

// File: rtl/dbg_hartctl_rd.sv
module dbg_hartctl_rd
    import dbg_hartctl_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             rd_hit,
    input  logic             rd_any,
    input  ctl_t             ctl_q,
    input  logic             auth_bit,
    output logic [REG_W-1:0] rdata
);
    logic [REG_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = '0;
        if (rd_hit) begin
            rdata_d[SEL_LO +: SEL_W] = ctl_q.sel;
            rdata_d[ACTIVE_BIT]      = ctl_q.active;
            rdata_d[SYSRST_BIT]      = ctl_q.sysrst;
            rdata_d[AUTH_BIT]        = auth_bit;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    // R2
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!por_n)
        !$past(rd_any) |-> (rdata_q == '0));

    // R10
    req_bits_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        $past(rd_hit) |-> (rdata_q[HALT_BIT] == 1'b0 && rdata_q[RESUME_BIT] == 1'b0));
endmodule

// File: rtl/dbg_hartctl.sv
module dbg_hartctl
    import dbg_hartctl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h40,
    parameter int unsigned NUM_HARTS = 8,
    parameter bit          HAS_AUTH  = 1'b0
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    input  logic [NUM_HARTS-1:0] hart_halted,
    input  logic                 auth_ok,
    output logic [NUM_HARTS-1:0] halt_pulse,
    output logic [NUM_HARTS-1:0] resume_pulse,
    output logic                 sys_reset,
    output logic                 dm_rst_n
);
    logic wr_hit, rd_hit, auth_bit;
    ctl_t ctl_q;
    req_t req;

    assign wr_hit = wr_en && (addr == CTRL_ADDR);
    assign rd_hit = rd_en && (addr == CTRL_ADDR);

    if (HAS_AUTH) begin : g_auth
        assign auth_bit = auth_ok;
    end else begin : g_noauth
        assign auth_bit = 1'b1;
    end

    logic unused_bits;
    assign unused_bits = ^{wdata[29:26], wdata[15:10], wdata[7:0], auth_ok};

    dbg_hartctl_regs u_regs (
        .clk    (clk),
        .por_n  (por_n),
        .wr_hit (wr_hit),
        .wdata  (wdata),
        .ctl_q  (ctl_q),
        .req    (req)
    );

    dbg_hartctl_req #(.NUM_HARTS(NUM_HARTS)) u_req (
        .clk          (clk),
        .por_n        (por_n),
        .req          (req),
        .hart_halted  (hart_halted),
        .halt_pulse   (halt_pulse),
        .resume_pulse (resume_pulse)
    );

    dbg_hartctl_rd u_rd (
        .clk      (clk),
        .por_n    (por_n),
        .rd_hit   (rd_hit),
        .rd_any   (rd_en),
        .ctl_q    (ctl_q),
        .auth_bit (auth_bit),
        .rdata    (rdata)
    );

    assign sys_reset = ctl_q.sysrst;
    assign dm_rst_n  = ctl_q.active;

    // R3
    local_reset_follow_chk: assert property (@(posedge clk) disable iff (!por_n)
        $past(wr_hit) |-> (dm_rst_n == $past(wdata[ACTIVE_BIT])));
endmodule

// File: tb/tb_dbg_hartctl.sv
module tb_dbg_hartctl;
    localparam int NH = 8;
    localparam logic [7:0] CA = 8'h40;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, auth_ok = 1'b0;
    logic [7:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NH-1:0] hart_halted = '0;
    logic [NH-1:0] halt_pulse, resume_pulse;
    logic sys_reset, dm_rst_n;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dbg_hartctl dut (
        .clk(clk), .por_n(por_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .hart_halted(hart_halted), .auth_ok(auth_ok),
        .halt_pulse(halt_pulse), .resume_pulse(resume_pulse),
        .sys_reset(sys_reset), .dm_rst_n(dm_rst_n)
    );

    typedef struct {
        logic [31:0]   rdata;
        logic [NH-1:0] halt;
        logic [NH-1:0] resume;
        logic          sys;
        logic          act;
        string         tag;
    } item_t;

    item_t q[$];

    // requirement model
    logic       m_active = 1'b0;
    logic       m_sys    = 1'b0;
    logic [9:0] m_sel    = '0;

    function automatic logic [31:0] mk(input logic h, input logic r, input int sel,
                                       input logic act, input logic sys);
        logic [31:0] v = '0;
        v[31] = h; v[30] = r; v[25:16] = 10'(sel); v[9] = act; v[8] = sys;
        return v;
    endfunction

    task automatic op(input logic w, input logic r, input logic [7:0] a,
                      input logic [31:0] d, input logic [NH-1:0] hh, input string tag);
        item_t it;
        int sel;
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d; hart_halted = hh;
        it.rdata = '0; it.halt = '0; it.resume = '0;
        if (r && a == CA) begin
            it.rdata[25:16] = m_sel; it.rdata[9] = m_active;
            it.rdata[8] = m_sys; it.rdata[7] = 1'b1;
        end
        if (w && a == CA) begin
            if (m_active && d[9]) begin
                sel = int'(d[25:16]);
                if (sel < NH) begin
                    if (d[31]) begin
                        if (!hh[sel]) it.halt[sel] = 1'b1;
                    end else if (d[30] && hh[sel]) begin
                        it.resume[sel] = 1'b1;
                    end
                end
                m_sys = d[8]; m_sel = d[25:16];
            end else begin
                m_sys = 1'b0; m_sel = '0;
            end
            m_active = d[9];
        end
        it.sys = m_sys; it.act = m_active; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic cmp(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // monitor: compares outputs after each registered step
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                it = q.pop_front();
                cmp(it.tag, "rdata", rdata, it.rdata);
                cmp(it.tag, "halt_pulse", 32'(halt_pulse), 32'(it.halt));
                cmp(it.tag, "resume_pulse", 32'(resume_pulse), 32'(it.resume));
                cmp(it.tag, "sys_reset", 32'(sys_reset), 32'(it.sys));
                cmp(it.tag, "dm_rst_n", 32'(dm_rst_n), 32'(it.act));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        // R1 reset state
        op(0, 1, CA, 0, '0, "R1 reset read");
        op(0, 0, 0, 0, '0, "R1 idle");
        // R4 activating write carries other fields; R13 no pulse
        op(1, 0, CA, mk(1, 0, 5, 1, 1), '0, "R4 R13 activate");
        op(0, 1, CA, 0, '0, "R4 readback");
        // R2 other address
        op(1, 0, 8'h41, mk(0, 0, 3, 0, 1), '0, "R2 foreign write");
        op(0, 1, 8'h41, 0, '0, "R2 foreign read");
        op(0, 1, CA, 0, '0, "R2 unchanged");
        // R5 R6 system reset and select
        op(1, 0, CA, mk(0, 0, 3, 1, 1), '0, "R5 assert sysrst");
        op(0, 1, CA, 0, '0, "R6 select readback");
        op(1, 0, CA, mk(0, 0, 3, 1, 0), '0, "R5 release sysrst");
        // R7 halt to same-write select, one cycle
        op(1, 0, CA, mk(1, 0, 2, 1, 0), '0, "R7 halt hart2");
        op(0, 1, CA, 0, '0, "R7 R10 pulse ends, bits read 0");
        op(1, 0, CA, mk(1, 0, 6, 1, 0), 8'h40, "R7 halt already halted");
        // R8 resume
        op(1, 0, CA, mk(0, 1, 6, 1, 0), 8'h40, "R8 resume halted hart6");
        op(1, 0, CA, mk(0, 1, 1, 1, 0), 8'h40, "R8 resume running hart1");
        // R9 both bits
        op(1, 0, CA, mk(1, 1, 4, 1, 0), 8'h40, "R9 both running hart4");
        op(1, 0, CA, mk(1, 1, 6, 1, 0), 8'h40, "R9 both halted hart6");
        // R12 out of range
        op(1, 0, CA, mk(1, 0, 900, 1, 0), '0, "R12 halt hart900");
        op(1, 0, CA, mk(0, 1, 901, 1, 0), 8'hFF, "R12 resume hart901");
        op(0, 1, CA, 0, '0, "R6 R10 select 901 readback");
        // R3 deactivate clears fields
        op(1, 0, CA, mk(0, 0, 7, 1, 1), '0, "R3 set sysrst");
        op(1, 0, CA, mk(0, 0, 7, 0, 1), '0, "R3 deactivate");
        op(0, 1, CA, 0, '0, "R3 cleared read");
        // R13 requests while inactive
        op(1, 0, CA, mk(1, 0, 0, 0, 0), '0, "R13 halt inactive");
        op(1, 0, CA, mk(1, 0, 0, 1, 0), '0, "R13 halt on activate");
        // R11 authentication bit constant
        auth_ok = 1'b0;
        op(0, 1, CA, 0, '0, "R11 auth reads 1");
        op(1, 0, CA, mk(1, 0, 0, 1, 0), '0, "R7 halt hart0 after activate");
        op(0, 0, 0, 0, '0, "R7 idle");
        op(0, 0, 0, 0, '0, "idle");
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule